// File: doc/BRIEF.md
# Convergent Rounding Word-Width Reducer

This block takes a wide two's-complement accumulator word, such as the sum that a short FIR filter produces, and reduces it to a narrow signed sample for a low-resolution DAC. By default the input is 22 bits and the output is 8 bits, so the 14 least significant bits are dropped and only the top 8 are kept. The way those dropped bits change the kept bits depends on a 2-bit select. The default rounding method is round-half-to-even, which adds no DC offset to the signal. The other three methods can be selected at run time so that their bias can be measured against it.

Each accepted word produces exactly one registered result one clock later. When rounding would carry the largest positive kept value past its limit, the result clamps to the positive maximum and a per-sample overflow flag is raised. Cycles in which no word is offered leave the output registers unchanged.

Top module: `conv_round_reducer`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_data` and `out_ovf` become 0.
- R2: A word accepted with `in_valid` high at edge k appears on `out_data`/`out_ovf` after edge k with `out_valid` high. Back-to-back words each give their own result, one cycle later.
- R3: When `in_valid` is low at an edge, `out_valid` is low after that edge and `out_data` and `out_ovf` keep their previous values.
- R4: `in_mode` = 2'b00 (truncate): `out_data` = `in_data[21:14]`, and `out_ovf` = 0.
- R5: `in_mode` = 2'b01 (add-half): `out_data` = `in_data[21:14]` + `in_data[13]`. For example, 22'h002000 gives 8'h01.
- R6: `in_mode` = 2'b10 (convergent): when the dropped part `in_data[13:0]` is not exactly 14'h2000, the result is the nearest output value.
- R7: In convergent mode, a tie (`in_data[13]`=1 and `in_data[12:0]`=0) rounds to the even kept value. 22'h002000 gives 8'h00, 22'h006000 gives 8'h02, and 22'h00A000 gives 8'h02.
- R8: `in_mode` = 2'b11 (symmetric): the result is the nearest output value, and ties round away from zero. A negative tie stays at the floor; a positive tie steps up.
- R9: If the rounding increment applies while `in_data[21:14]` = 8'h7F, `out_data` = 8'h7F and `out_ovf` = 1 for that sample. In every other case `out_ovf` = 0.
- R10: For the extreme input -2^21 (22'h200000), every mode gives 8'h80 with no overflow. For 2^21-1 (22'h1FFFFF), truncate gives 8'h7F with no overflow, and the other three modes give 8'h7F with overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 22 | Two's-complement accumulator word |
| in_mode | input | 2 | Rounding method: 00 truncate, 01 add-half, 10 convergent, 11 symmetric |
| out_valid | output | 1 | Result register was loaded on the last edge |
| out_data | output | 8 | Reduced signed sample |
| out_ovf | output | 1 | Result was clamped at the positive limit |

## Verification
Ties are the case the bench targets most. It sweeps every exactly-halfway input across the full signed range in all four modes:
- A design that ignores the tie case rounds every half upward and shows a positive bias.
- A design with the parity test inverted lands on odd values.
- A design that treats symmetric mode like add-half moves negative ties toward zero.

The positive saturation edge and the two extreme inputs expose an increment that wraps 8'h7F to 8'h80, and an overflow flag that is stuck or set in truncate mode. Idle cycles with changing input data expose a result register that loads without `in_valid`. Streamed back-to-back words expose a latency other than one cycle.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    MODE_TRUNC  = 2'b00,
    MODE_HALFUP = 2'b01,
    MODE_CONV   = 2'b10,
    MODE_SYM    = 2'b11
  } rndMode_t;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic load;     // capture a new result this edge
    logic roundEn;  // any rounding increment allowed
    logic tieEven;  // ties resolve to even kept value
    logic tieAway;  // ties resolve away from zero
  } rndStrobe_t;

endpackage

// File: rtl/rnd_ctrl.sv
module rnd_ctrl
  import rnd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] inMode,
  output rndStrobe_t ctl,
  output logic       outValid
);

  rndMode_t modeSel;

  always_comb begin
    modeSel     = rndMode_t'(inMode);
    ctl.load    = inValid;
    ctl.roundEn = (modeSel != MODE_TRUNC);
    ctl.tieEven = (modeSel == MODE_CONV);
    ctl.tieAway = (modeSel == MODE_SYM);
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R2: an accepted word always yields a valid result next cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R3: no input, no output strobe
  a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/rnd_datapath.sv
module rnd_datapath
  import rnd_pkg::*;
#(
  parameter int IN_W  = 22,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  rndStrobe_t       ctl,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData,
  output logic             overflow
);

  localparam int DROP = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] kept;
  logic             halfBit;
  logic             restZero;
  logic             signBit;
  logic             tie;
  logic             incr;
  logic             sat;
  logic [OUT_W-1:0] nextData;

  always_comb begin
    kept     = inData[IN_W-1:DROP];
    halfBit  = inData[DROP-1];
    restZero = (inData[DROP-2:0] == '0);
    signBit  = inData[IN_W-1];
    tie      = halfBit & restZero;
    // Start from add-half, then veto the increment on ties where the
    // selected method says to stay at the lower value.
    incr     = ctl.roundEn & halfBit
             & ~(tie & ctl.tieEven & ~kept[0])
             & ~(tie & ctl.tieAway & signBit);
    sat      = incr & (kept == MAX_POS);
    nextData = sat ? MAX_POS : kept + {{(OUT_W-1){1'b0}}, incr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      overflow <= 1'b0;
    end else if (ctl.load) begin
      outData  <= nextData;
      overflow <= sat;
    end
  end

  // R3: registers hold when nothing is loaded
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> ($stable(outData) && $stable(overflow)));

  // R4: truncation passes the kept bits and never overflows
  a_r4_trunc_exact: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !ctl.roundEn) |=>
      (outData == $past(inData[IN_W-1:DROP]) && !overflow));

  // R7: a convergent tie lands on an even value unless clamped
  a_r7_tie_even: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.tieEven && tie) |=> (!outData[0] || overflow));

  // R9: overflow only accompanies the clamped maximum
  a_r9_ovf_saturated: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (outData == MAX_POS));

endmodule

// File: rtl/conv_round_reducer.sv
module conv_round_reducer
  import rnd_pkg::*;
#(
  parameter int IN_W  = 22,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf
);

  rndStrobe_t strobes;

  rnd_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (in_valid),
    .inMode   (in_mode),
    .ctl      (strobes),
    .outValid (out_valid)
  );

  rnd_datapath #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (strobes),
    .inData   (in_data),
    .outData  (out_data),
    .overflow (out_ovf)
  );

endmodule

// File: tb/conv_round_reducer_tb.sv
module conv_round_reducer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [21:0] in_data = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_round_reducer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .out_valid(out_valid), .out_data(out_data),
    .out_ovf(out_ovf)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Integer reference: floor division plus a per-method decision on the remainder
  function automatic void refModel(input int x, input int m, output int q, output int ov);
    int base;
    int rem;
    int up;
    base = x >>> 14;
    rem  = x - base * 16384;
    case (m)
      0: up = 0;
      1: up = (rem >= 8192) ? 1 : 0;
      2: up = (rem > 8192 || (rem == 8192 && (base & 1) != 0)) ? 1 : 0;
      default: up = (rem > 8192 || (rem == 8192 && x >= 0)) ? 1 : 0;
    endcase
    q  = base + up;
    ov = 0;
    if (q > 127) begin q = 127; ov = 1; end
    q = q & 255;
  endfunction

  function automatic string modeTag(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic int nextRand();
    int v;
    lcg = lcg * 32'd1103515245 + 32'd12345;
    v = int'((lcg >> 8) & 32'h3F_FFFF);
    if (v >= 2097152) v -= 4194304;
    return v;
  endfunction

  task automatic applyOne(input int x, input int m, input string req);
    int q;
    int ov;
    refModel(x, m, q, ov);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x[21:0];
    in_mode  = m[1:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " data"}, int'(out_data), q);
    chk({req, " ovf"}, int'(out_ovf), ov);
    chk("R2 valid", int'(out_valid), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 data", int'(out_data), 0);
    chk("R1 ovf", int'(out_ovf), 0);
    rst = 1'b0;
  endtask

  task automatic testTieExamples();
    applyOne(32'h002000, 2, "R7 0x002000");
    chk("R7 ex0", int'(out_data), 0);
    applyOne(32'h006000, 2, "R7 0x006000");
    chk("R7 ex1", int'(out_data), 2);
    applyOne(32'h00A000, 2, "R7 0x00A000");
    chk("R7 ex2", int'(out_data), 2);
    applyOne(32'h002000, 1, "R5 0x002000");
    chk("R5 ex", int'(out_data), 1);
  endtask

  task automatic testTieSweep();
    for (int k = -128; k < 128; k++) begin
      applyOne(k * 16384 + 8192, 2, "R7 tie");
      applyOne(k * 16384 + 8192, 3, "R8 tie");
      applyOne(k * 16384 + 8192, 1, "R5 tie");
      applyOne(k * 16384 + 8192, 0, "R4 tie");
    end
  endtask

  task automatic testPseudoRandom();
    for (int i = 0; i < 1600; i++) begin
      int x;
      x = nextRand();
      applyOne(x, i % 4, modeTag(i % 4));
    end
  endtask

  task automatic testExtremes();
    for (int m = 0; m < 4; m++) begin
      applyOne(-2097152, m, "R10 min");
      chk("R10 min data", int'(out_data), 128);
      chk("R10 min ovf", int'(out_ovf), 0);
      applyOne(2097151, m, "R10 max");
      chk("R10 max data", int'(out_data), 127);
      chk("R10 max ovf", int'(out_ovf), (m == 0) ? 0 : 1);
    end
  endtask

  task automatic testSaturation();
    applyOne(127 * 16384 + 8192, 2, "R9 tie clamp");
    chk("R9 tie clamp ovf", int'(out_ovf), 1);
    applyOne(127 * 16384 + 8191, 1, "R9 below half");
    chk("R9 no clamp ovf", int'(out_ovf), 0);
    chk("R9 no clamp data", int'(out_data), 127);
    applyOne(126 * 16384 + 9000, 3, "R9 126 up");
    chk("R9 126 up data", int'(out_data), 127);
    chk("R9 126 up ovf", int'(out_ovf), 0);
  endtask

  task automatic testStream();
    int expQ[8];
    int expO[8];
    int vals[8];
    for (int i = 0; i < 8; i++) begin
      vals[i] = nextRand();
      refModel(vals[i], 2, expQ[i], expO[i]);
    end
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2 stream valid", int'(out_valid), 1);
        chk("R2 stream data", int'(out_data), expQ[i-1]);
        chk("R2 stream ovf", int'(out_ovf), expO[i-1]);
      end
      if (i < 8) begin
        in_valid = 1'b1;
        in_data  = vals[i][21:0];
        in_mode  = 2'b10;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic testHold();
    applyOne(127 * 16384 + 8192, 1, "R3 setup");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 22'h200000 + i[21:0];
      in_mode  = i[1:0];
      @(negedge clk);
      chk("R3 idle valid", int'(out_valid), 0);
      chk("R3 held data", int'(out_data), 127);
      chk("R3 held ovf", int'(out_ovf), 1);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testTieExamples();
    testTieSweep();
    testPseudoRandom();
    testExtremes();
    testSaturation();
    testStream();
    testHold();
    finishRun();
  end

endmodule